// File: doc/BRIEF.md
# Grouped DMA Interrupt Status Controller

This block turns single-cycle transfer-event pulses from a DMA engine into sticky status bits and raises one level interrupt toward the processor. The event sources fall into two groups: a normal group and an abnormal group. A mask register picks which sources take part in interrupt generation. For each group the block forms a summary bit: the OR of that group's status bits whose mask bit is set. The interrupt output is the registered OR of the two summaries.

Software works through a small register port with one address bit, a write strobe, write data and a combinational read-data bus. Address 0 holds the status register. It has the per-source sticky bits and the two read-only summary bits, and each status bit is cleared by writing 1 to it. Address 1 holds the mask register, which can be read and written. An event that recurs while its bit is still set is absorbed. Several events in one cycle give a single interrupt assertion. When a set pulse and a clear land on the same bit in the same cycle, the set wins.

Top module: `dma_irq_stat`

## Requirements
- R1: A one-cycle pulse on source input bit i sets status bit i at the next clock edge. The bit stays set after the pulse ends, until software clears it. Status layout: normal source j at bit j, abnormal source j at bit NORM_N+j.
- R2: Status bits read back at address 0 whatever the mask holds. A source with its mask bit at 0 still shows its status.
- R3: Status bit NORM_N+ABN_N (bit 16 by default) reads as the OR of the normal status bits whose mask bit is 1.
- R4: Status bit NORM_N+ABN_N+1 (bit 17 by default) reads as the OR of the abnormal status bits whose mask bit is 1.
- R5: A write to address 0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R6: A summary bit drops as soon as every status bit in its group that has its mask bit at 1 is 0. This holds even when status bits with their mask bit at 0 remain set.
- R7: A pulse on a source whose status bit is already set changes no status bit. It also causes no drop or new rising edge on the interrupt output.
- R8: Pulses on several sources in the same cycle produce exactly one rising edge of the interrupt output.
- R9: The interrupt output equals, one clock later, the OR of the two summary bits.
- R10: When a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Writes to the summary bit positions have no effect. The mask register at address 1 reads back the value last written to it: normal mask in bits 7:0 and abnormal mask in bits 15:8 by default, with the same layout as the status bits. All other read bits are 0.
- R12: After synchronous reset, all status bits, the mask and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_norm | input | NORM_N | Normal-group event pulses, one per source |
| evt_abn | input | ABN_N | Abnormal-group event pulses, one per source |
| reg_addr | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register (combinational) |
| irq | output | 1 | Registered level interrupt |

## Verification
Every one of the sixteen sources is taken in turn through the same cycle: a single pulse, a repeat pulse while set, a zero write, and a one write. This separates the per-bit set and clear paths and shows which group summary each bit feeds. The mask is then swept through all-zero and single-bit settings while events stay pending. This separates status visibility from summary formation, and shows whether summaries fall while masked-off bits are still set. Simultaneous multi-source bursts, set-versus-clear collisions and writes aimed at the summary positions cover the interrupt edge count, the set priority and the read-only bits. The bench compares against a cycle-level arithmetic model at every step.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    // Default group sizes and register width
    localparam int unsigned DEF_NORM_N = 8;
    localparam int unsigned DEF_ABN_N  = 8;
    localparam int unsigned DEF_DATA_W = 32;

    // Register selection on the one-bit address
    typedef enum logic [0:0] {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // Per-group summary pair
    typedef struct packed {
        logic abn;
        logic norm;
    } summary_t;

    // Decoded register-port write operation
    typedef struct packed {
        logic     active;
        reg_sel_e sel;
    } wr_op_t;

    function automatic wr_op_t decode_write(input logic wr, input logic addr);
        wr_op_t op;
        op.active = wr;
        op.sel    = reg_sel_e'(addr);
        return op;
    endfunction

    function automatic logic summary_any(input summary_t s);
        return s.norm | s.abn;
    endfunction

endpackage

// File: rtl/dirq_status_bank.sv
module dirq_status_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    // One sticky bit per source; a set pulse outranks a clear request
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_o[b] <= 1'b0;
            end else if (set_i[b]) begin
                stat_o[b] <= 1'b1;
            end else if (clr_i[b]) begin
                stat_o[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dirq_summary.sv
module dirq_summary #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] mask_i,
    output logic         sum_o
);

    logic [N-1:0] enabled;

    always_comb begin
        enabled = stat_i & mask_i;
        sum_o   = |enabled;
    end

endmodule

// File: rtl/dirq_regs.sv
module dirq_regs
    import dirq_pkg::*;
#(
    parameter int unsigned NORM_N = DEF_NORM_N,
    parameter int unsigned ABN_N  = DEF_ABN_N,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NORM_N-1:0] stat_norm,
    input  logic [ABN_N-1:0]  stat_abn,
    input  summary_t          sum_i,
    output logic [NORM_N-1:0] mask_norm,
    output logic [ABN_N-1:0]  mask_abn,
    output logic [NORM_N-1:0] clr_norm,
    output logic [ABN_N-1:0]  clr_abn,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned SRC_N    = NORM_N + ABN_N;
    localparam int unsigned NSUM_BIT = SRC_N;
    localparam int unsigned ASUM_BIT = SRC_N + 1;

    wr_op_t op;

    always_comb begin
        op = decode_write(reg_wr, reg_addr);
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_norm <= '0;
            mask_abn  <= '0;
        end else if (op.active && op.sel == SEL_MASK) begin
            mask_norm <= reg_wdata[NORM_N-1:0];
            mask_abn  <= reg_wdata[SRC_N-1:NORM_N];
        end
    end

    // Write-one-to-clear requests toward the status banks
    always_comb begin
        clr_norm = '0;
        clr_abn  = '0;
        if (op.active && op.sel == SEL_STATUS) begin
            clr_norm = reg_wdata[NORM_N-1:0];
            clr_abn  = reg_wdata[SRC_N-1:NORM_N];
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_STATUS: begin
                reg_rdata[NORM_N-1:0]     = stat_norm;
                reg_rdata[SRC_N-1:NORM_N] = stat_abn;
                reg_rdata[NSUM_BIT]       = sum_i.norm;
                reg_rdata[ASUM_BIT]       = sum_i.abn;
            end
            SEL_MASK: begin
                reg_rdata[NORM_N-1:0]     = mask_norm;
                reg_rdata[SRC_N-1:NORM_N] = mask_abn;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat
    import dirq_pkg::*;
#(
    parameter int unsigned NORM_N = DEF_NORM_N,
    parameter int unsigned ABN_N  = DEF_ABN_N,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NORM_N-1:0] evt_norm,
    input  logic [ABN_N-1:0]  evt_abn,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int unsigned SRC_N = NORM_N + ABN_N;

    initial begin
        if (DATA_W < SRC_N + 2) $error("DATA_W too small for status layout");
    end

    logic [NORM_N-1:0] stat_norm, mask_norm, clr_norm;
    logic [ABN_N-1:0]  stat_abn,  mask_abn,  clr_abn;
    summary_t          sum;

    dirq_status_bank #(.N(NORM_N)) u_bank_norm (
        .clk(clk), .rst(rst), .set_i(evt_norm), .clr_i(clr_norm), .stat_o(stat_norm)
    );

    dirq_status_bank #(.N(ABN_N)) u_bank_abn (
        .clk(clk), .rst(rst), .set_i(evt_abn), .clr_i(clr_abn), .stat_o(stat_abn)
    );

    dirq_summary #(.N(NORM_N)) u_sum_norm (
        .stat_i(stat_norm), .mask_i(mask_norm), .sum_o(sum.norm)
    );

    dirq_summary #(.N(ABN_N)) u_sum_abn (
        .stat_i(stat_abn), .mask_i(mask_abn), .sum_o(sum.abn)
    );

    dirq_regs #(.NORM_N(NORM_N), .ABN_N(ABN_N), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .stat_norm(stat_norm), .stat_abn(stat_abn), .sum_i(sum),
        .mask_norm(mask_norm), .mask_abn(mask_abn),
        .clr_norm(clr_norm), .clr_abn(clr_abn),
        .reg_rdata(reg_rdata)
    );

    // Registered level interrupt
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= summary_any(sum);
    end

endmodule

// File: rtl/dma_irq_stat_chk.sv
module dma_irq_stat_chk #(
    parameter int unsigned NORM_N = 8,
    parameter int unsigned ABN_N  = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NORM_N-1:0] evt_norm,
    input logic [ABN_N-1:0]  evt_abn,
    input logic              reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NORM_N-1:0] stat_norm,
    input logic [ABN_N-1:0]  stat_abn,
    input logic              sum_norm,
    input logic              sum_abn,
    input logic              irq
);

    localparam int unsigned SRC_N = NORM_N + ABN_N;

    logic [SRC_N-1:0] st, ev, clr;
    logic             pv;

    always_comb begin
        st  = {stat_abn, stat_norm};
        ev  = {evt_abn, evt_norm};
        clr = (reg_wr && !reg_addr) ? reg_wdata[SRC_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
    end

    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (stat_norm == '0 && stat_abn == '0 && irq == 1'b0));

    a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
        pv |-> (irq == ($past(sum_norm) | $past(sum_abn))));

    a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
        pv |-> ((st & ($past(st) & ~$past(clr))) == ($past(st) & ~$past(clr))));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        pv |-> ((st & $past(ev)) == $past(ev)));

    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        pv |-> ((st & $past(clr) & ~$past(ev)) == '0));

endmodule

bind dma_irq_stat dma_irq_stat_chk #(.NORM_N(NORM_N), .ABN_N(ABN_N), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .evt_norm(evt_norm), .evt_abn(evt_abn),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .stat_norm(stat_norm), .stat_abn(stat_abn),
    .sum_norm(sum.norm), .sum_abn(sum.abn), .irq(irq)
);

// File: tb/dma_irq_stat_test.sv
module dma_irq_stat_test;

    localparam int NN = 8;
    localparam int NA = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NN-1:0] evt_norm = '0;
    logic [NA-1:0] evt_abn = '0;
    logic          reg_addr = 1'b0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    integer n_chk = 0;
    integer n_bad = 0;
    integer rises = 0;
    logic   irq_prev = 1'b0;
    logic   done = 1'b0;

    // bench model
    logic [15:0] m_st = '0;
    logic [15:0] m_mk = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    dma_irq_stat uut (
        .clk(clk), .rst(rst), .evt_norm(evt_norm), .evt_abn(evt_abn),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] v;
        v = {16'h0, m_st};
        v[16] = |(m_st[7:0] & m_mk[7:0]);
        v[17] = |(m_st[15:8] & m_mk[15:8]);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, release, then compare
    task automatic step(input string tag, input logic [15:0] ev, input logic wr,
                        input logic adr, input logic [31:0] wd);
        logic [15:0] clr;
        logic        sum_old;
        evt_norm  = ev[7:0];
        evt_abn   = ev[15:8];
        reg_wr    = wr;
        reg_addr  = adr;
        reg_wdata = wd;
        @(posedge clk);
        sum_old = |(m_st[7:0] & m_mk[7:0]) | |(m_st[15:8] & m_mk[15:8]);
        clr = (wr && !adr) ? wd[15:0] : 16'h0;
        if (wr && adr) m_mk = wd[15:0];
        m_st  = (m_st & ~clr) | ev;
        m_irq = sum_old;
        @(negedge clk);
        evt_norm = '0;
        evt_abn  = '0;
        reg_wr   = 1'b0;
        reg_addr = 1'b0;
        #1;
        chk({tag, " status"}, reg_rdata, exp_status());
        chk({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
        if (irq && !irq_prev) rises++;
        irq_prev = irq;
    endtask

    task automatic read_mask(input string tag);
        reg_addr = 1'b1;
        #1;
        chk(tag, reg_rdata, {16'h0, m_mk});
        reg_addr = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 status", reg_rdata, 32'h0);
        chk("R12 irq", {31'h0, irq}, 32'h0);
        read_mask("R12 mask");

        // R11 mask write/readback
        step("R11 mask wr", 16'h0, 1'b1, 1'b1, 32'hFFFF_A5A5);
        m_mk = 16'hA5A5;
        read_mask("R11 mask rb");
        step("R11 mask all", 16'h0, 1'b1, 1'b1, 32'h0000_FFFF);
        read_mask("R11 mask rb2");

        // per-source sweep: R1 set, R3/R4 summary, R9 irq lag, R7 repeat, R5 w1c, R6 drop
        for (int i = 0; i < 16; i++) begin
            step("R1 set", 16'(1 << i), 1'b0, 1'b0, 32'h0);
            step("R9 irq lag", 16'h0, 1'b0, 1'b0, 32'h0);
            step("R7 repeat", 16'(1 << i), 1'b0, 1'b0, 32'h0);
            step("R5 zero write", 16'h0, 1'b1, 1'b0, ~(32'(1) << i) & 32'h0000_0000);
            step("R5 w1c", 16'h0, 1'b1, 1'b0, 32'(1) << i);
            step("R6 after clear", 16'h0, 1'b0, 1'b0, 32'h0);
        end
        chk("R7 single rise per source", rises, 16);

        // R2 mask zero still shows status
        step("R2 mask zero", 16'h0, 1'b1, 1'b1, 32'h0);
        step("R2 all events", 16'hFFFF, 1'b0, 1'b0, 32'h0);
        step("R2 idle", 16'h0, 1'b0, 1'b0, 32'h0);
        // mask sweep, one bit at a time
        for (int i = 0; i < 16; i++) begin
            step("R3 R4 mask sweep", 16'h0, 1'b1, 1'b1, 32'(1) << i);
            step("R9 mask sweep irq", 16'h0, 1'b0, 1'b0, 32'h0);
        end
        step("R5 clear all", 16'h0, 1'b1, 1'b0, 32'h0000_FFFF);
        step("R5 settle", 16'h0, 1'b0, 1'b0, 32'h0);

        // R6 masked-off leftover does not hold summary
        step("R6 mask", 16'h0, 1'b1, 1'b1, 32'h0000_0101);
        step("R6 events", 16'h0303, 1'b0, 1'b0, 32'h0);
        step("R6 clear enabled", 16'h0, 1'b1, 1'b0, 32'h0000_0101);
        step("R6 settle", 16'h0, 1'b0, 1'b0, 32'h0);
        step("R6 clear rest", 16'h0, 1'b1, 1'b0, 32'h0000_0202);

        // R8 simultaneous events -> one rise
        step("R8 mask", 16'h0, 1'b1, 1'b1, 32'h0000_FFFF);
        step("R8 idle", 16'h0, 1'b0, 1'b0, 32'h0);
        rises = 0;
        step("R8 burst", 16'h8421, 1'b0, 1'b0, 32'h0);
        for (int k = 0; k < 4; k++) step("R8 hold", 16'h0, 1'b0, 1'b0, 32'h0);
        chk("R8 one rise", rises, 1);

        // R10 set beats clear on the same bit
        step("R10 collide", 16'h0008, 1'b1, 1'b0, 32'h0000_0008);
        step("R10 collide2", 16'h1000, 1'b1, 1'b0, 32'h0000_1008);
        step("R10 settle", 16'h0, 1'b0, 1'b0, 32'h0);

        // R11 summary bits are read-only
        step("R11 w1c summary", 16'h0, 1'b1, 1'b0, 32'h0003_0000);
        step("R11 zero summary", 16'h0, 1'b1, 1'b0, 32'hFFFC_0000);
        step("R11 settle", 16'h0, 1'b0, 1'b0, 32'h0);
        read_mask("R11 mask unchanged");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule